// File: doc/BRIEF.md
# Wheel Drive Valve Supervisor

This block supervises one hydraulically driven wheel. It takes a direction and a target rotation rate, and on each sample tick it nudges a proportional flow command up or down so that the measured wheel rate settles on the target. The command may move by at most one fixed step per tick. A change of direction is taken up only after the flow command has been wound down to zero.

On every driving tick the block also checks two things. It checks the measured line pressure against a programmable window. It also checks how far the measured rate is from the target. If the pressure is out of its window, or the rate error stays beyond a tolerance for too long, the wheel is dropped at once into an unpowered freewheel. A latched "wheel lost" flag is then raised and held until the fault is explicitly cleared. Separately, an energy-saving request can place the wheel into the same freewheel without raising the flag.

The controller has four states:
- `ST_RUN`: regulating.
- `ST_TURN`: winding the flow down before a direction reversal.
- `ST_ECO`: commanded freewheel.
- `ST_FAULT`: fault freewheel with the flag set.

The state transitions are:
- `RUN->FAULT`: pressure trip or unsteady speed.
- `RUN->ECO`: energy request.
- `RUN->TURN`: direction differs.
- `TURN->FAULT`: pressure trip.
- `TURN->ECO`: energy request.
- `TURN->RUN`: flow at zero; the new direction is taken.
- `ECO->RUN`: request withdrawn.
- `FAULT->RUN` or `FAULT->ECO`: clear accepted.

Top module: `wheel_valve_supervisor`

## Requirements
- R1: After reset the flow command is 0, the direction output is 0 (forward), and both bypass and the lost flag are 0.
- R2: On a tick in regulation, with the commanded direction equal to the applied one, the flow rises by STEP if the measured rate is below the target. It falls by STEP if the measured rate is above the target. Otherwise it holds. A rise saturates at the maximum code and a fall saturates at 0. Without a tick, the flow does not change.
- R3: Between any two cycles in which bypass is 0, the flow command changes by no more than STEP.
- R4: On a tick while driving (regulating or turning), a pressure below the minimum or above the maximum puts the wheel into fault bypass in the next cycle. Both limits count as inside the window.
- R5: A rate error |measured − target| greater than TOL on more than HOLD_TICKS consecutive regulation ticks causes a fault. An error equal to TOL does not count. A tick within tolerance restarts the count.
- R6: Whenever bypass is 1, the flow command is 0. Bypass is 1 in both the commanded freewheel and the fault freewheel.
- R7: The lost flag is set on entry to fault bypass. It stays set until fault_clr is asserted in a cycle where the pressure is inside the window and the rate error is within TOL. A clear under any other condition is ignored.
- R8: eco_bypass, sampled on a tick, moves the wheel to freewheel with the lost flag at 0. In that freewheel, pressure and speed are not supervised. The wheel leaves only on a tick with eco_bypass at 0, and the flow then restarts from 0.
- R9: When the commanded direction differs from the applied one, the flow falls by STEP per tick. The direction output takes the new value only on a tick where the flow is already 0. The rate error is not counted while turning.
- R10: When a fault and eco_bypass coincide on a tick, the fault wins and the lost flag is set. A clear accepted while eco_bypass is 1 leads to the commanded freewheel, not to regulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe; regulation and supervision act on it |
| cmd_dir | input | 1 | Commanded direction (0 forward, 1 reverse) |
| cmd_rate | input | RATE_W | Target wheel rate |
| meas_rate | input | RATE_W | Measured wheel rate |
| meas_press | input | PRESS_W | Measured line pressure |
| press_min | input | PRESS_W | Lowest acceptable pressure |
| press_max | input | PRESS_W | Highest acceptable pressure |
| eco_bypass | input | 1 | Request energy-saving freewheel |
| fault_clr | input | 1 | Request to clear the lost flag |
| flow_cmd | output | RATE_W | Proportional flow command to the valve |
| flow_dir | output | 1 | Applied direction |
| bypass | output | 1 | Wheel is freewheeling with no drive |
| wheel_lost | output | 1 | Latched fault flag |

## Verification
Two functions can fall in the same tick: a fault trip (pressure or unsteady speed) and the energy-saving request. The bench provokes this by holding eco_bypass high on the very tick where the pressure leaves its window, and again on the tick that completes an unsteady run. It passes only if the lost flag rises rather than a plain freewheel. A related clash is provoked by asserting a fault clear while eco_bypass is still high. There the bench expects the lost flag to fall while bypass stays set.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_TURN  = 2'd1,
        ST_ECO   = 2'd2,
        ST_FAULT = 2'd3
    } wvs_state_e;

    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2,
        SLEW_ZERO = 2'd3
    } wvs_slew_e;
endpackage

// File: rtl/wvs_window_check.sv
module wvs_window_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         outside
);
    always_comb begin
        outside = (value < lo) || (value > hi);
    end
endmodule

// File: rtl/wvs_stability_monitor.sv
module wvs_stability_monitor #(
    parameter int W          = 8,
    parameter int TOL        = 3,
    parameter int HOLD_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         clr,
    input  logic [W-1:0] meas,
    input  logic [W-1:0] target,
    output logic         over_tol,
    output logic         unsteady
);
    localparam int            CW     = $clog2(HOLD_TICKS + 1);
    localparam logic [W-1:0]  TOL_X  = W'(TOL);
    localparam logic [CW-1:0] HOLD_X = CW'(HOLD_TICKS);

    logic [W-1:0]  diff;
    logic [CW-1:0] run_q;

    always_comb begin
        diff     = (meas > target) ? (meas - target) : (target - meas);
        over_tol = diff > TOL_X;
        unsteady = over_tol && (run_q == HOLD_X);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (arm) begin
            if (!over_tol) begin
                run_q <= '0;
            end else if (run_q < HOLD_X) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= HOLD_X);  // R5
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clr && !over_tol) |=> (run_q == '0));  // R5
endmodule

// File: rtl/wvs_flow_slew.sv
module wvs_flow_slew
    import wvs_pkg::*;
#(
    parameter int W    = 8,
    parameter int STEP = 4
) (
    input  logic [W-1:0] flow,
    input  wvs_slew_e    mode,
    output logic [W-1:0] flow_nxt
);
    localparam logic [W:0] STEP_X = (W+1)'(STEP);
    localparam logic [W:0] MAX_X  = {1'b0, {W{1'b1}}};

    logic [W:0] up_sum;

    always_comb begin
        up_sum = {1'b0, flow} + STEP_X;
        unique case (mode)
            SLEW_HOLD: flow_nxt = flow;
            SLEW_UP:   flow_nxt = (up_sum > MAX_X) ? {W{1'b1}} : up_sum[W-1:0];
            SLEW_DOWN: flow_nxt = ({1'b0, flow} < STEP_X) ? '0 : (flow - STEP_X[W-1:0]);
            default:   flow_nxt = '0;
        endcase
    end
endmodule

// File: rtl/wheel_valve_supervisor.sv
module wheel_valve_supervisor
    import wvs_pkg::*;
#(
    parameter int RATE_W     = 8,
    parameter int PRESS_W    = 8,
    parameter int STEP       = 4,
    parameter int TOL        = 3,
    parameter int HOLD_TICKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cmd_dir,
    input  logic [RATE_W-1:0]  cmd_rate,
    input  logic [RATE_W-1:0]  meas_rate,
    input  logic [PRESS_W-1:0] meas_press,
    input  logic [PRESS_W-1:0] press_min,
    input  logic [PRESS_W-1:0] press_max,
    input  logic               eco_bypass,
    input  logic               fault_clr,
    output logic [RATE_W-1:0]  flow_cmd,
    output logic               flow_dir,
    output logic               bypass,
    output logic               wheel_lost
);
    localparam logic [RATE_W:0] STEP_X = (RATE_W+1)'(STEP);

    wvs_state_e        state_q, state_d;
    wvs_slew_e         slew_mode;
    logic [RATE_W-1:0] flow_q, flow_d;
    logic              dir_q, dir_d;
    logic              press_bad, over_tol, unsteady;
    logic              mon_arm, mon_clr;

    wvs_window_check #(.W(PRESS_W)) u_press (
        .value   (meas_press),
        .lo      (press_min),
        .hi      (press_max),
        .outside (press_bad)
    );

    assign mon_arm = tick && (state_q == ST_RUN);
    assign mon_clr = (state_q != ST_RUN);

    wvs_stability_monitor #(.W(RATE_W), .TOL(TOL), .HOLD_TICKS(HOLD_TICKS)) u_speed (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (mon_arm),
        .clr      (mon_clr),
        .meas     (meas_rate),
        .target   (cmd_rate),
        .over_tol (over_tol),
        .unsteady (unsteady)
    );

    wvs_flow_slew #(.W(RATE_W), .STEP(STEP)) u_slew (
        .flow     (flow_q),
        .mode     (slew_mode),
        .flow_nxt (flow_d)
    );

    // transition logic
    always_comb begin
        state_d   = state_q;
        dir_d     = dir_q;
        slew_mode = SLEW_HOLD;
        unique case (state_q)
            ST_RUN: begin
                if (tick) begin
                    if (press_bad || unsteady) begin
                        state_d   = ST_FAULT;
                        slew_mode = SLEW_ZERO;
                    end else if (eco_bypass) begin
                        state_d   = ST_ECO;
                        slew_mode = SLEW_ZERO;
                    end else if (cmd_dir != dir_q) begin
                        state_d   = ST_TURN;
                        slew_mode = SLEW_DOWN;
                    end else if (meas_rate < cmd_rate) begin
                        slew_mode = SLEW_UP;
                    end else if (meas_rate > cmd_rate) begin
                        slew_mode = SLEW_DOWN;
                    end
                end
            end
            ST_TURN: begin
                if (tick) begin
                    if (press_bad) begin
                        state_d   = ST_FAULT;
                        slew_mode = SLEW_ZERO;
                    end else if (eco_bypass) begin
                        state_d   = ST_ECO;
                        slew_mode = SLEW_ZERO;
                    end else if (flow_q == '0) begin
                        state_d = ST_RUN;
                        dir_d   = cmd_dir;
                    end else begin
                        slew_mode = SLEW_DOWN;
                    end
                end
            end
            ST_ECO: begin
                slew_mode = SLEW_ZERO;
                if (tick && !eco_bypass) begin
                    state_d = ST_RUN;
                    dir_d   = cmd_dir;
                end
            end
            ST_FAULT: begin
                slew_mode = SLEW_ZERO;
                if (fault_clr && !press_bad && !over_tol) begin
                    state_d = eco_bypass ? ST_ECO : ST_RUN;
                    dir_d   = cmd_dir;
                end
            end
            default: begin
                state_d   = ST_FAULT;
                slew_mode = SLEW_ZERO;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            flow_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            flow_q  <= flow_d;
            dir_q   <= dir_d;
        end
    end

    // output decode
    always_comb begin
        flow_cmd   = flow_q;
        flow_dir   = dir_q;
        bypass     = (state_q == ST_ECO) || (state_q == ST_FAULT);
        wheel_lost = (state_q == ST_FAULT);
    end

    AST_SLEW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (({1'b0, flow_cmd} <= {1'b0, $past(flow_cmd)} + STEP_X) &&
                     ({1'b0, $past(flow_cmd)} <= {1'b0, flow_cmd} + STEP_X)));  // R3
    AST_BYPASS_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (flow_cmd == '0));  // R6
    AST_PRESS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bypass && press_bad) |=> wheel_lost);  // R4
    AST_SPEED_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (state_q == ST_RUN) && unsteady) |=> wheel_lost);  // R5
    AST_LOST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wheel_lost && !fault_clr) |=> wheel_lost);  // R7
    AST_DIR_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_dir != $past(flow_dir)) |-> ($past(flow_cmd) == '0));  // R9
endmodule

// File: tb/wheel_valve_supervisor_bench.sv
`timescale 1ns/1ps
module wheel_valve_supervisor_bench;
    localparam int RW   = 8;
    localparam int PW   = 8;
    localparam int STEP = 4;
    localparam int TOL  = 3;
    localparam int HOLD = 3;
    localparam int PMIN = 60;
    localparam int PMAX = 200;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic          cmd_dir;
    logic [RW-1:0] cmd_rate;
    logic [RW-1:0] meas_rate;
    logic [PW-1:0] meas_press;
    logic [PW-1:0] press_min;
    logic [PW-1:0] press_max;
    logic          eco_bypass;
    logic          fault_clr;
    logic [RW-1:0] flow_cmd;
    logic          flow_dir;
    logic          bypass;
    logic          wheel_lost;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    wheel_valve_supervisor #(
        .RATE_W(RW), .PRESS_W(PW), .STEP(STEP), .TOL(TOL), .HOLD_TICKS(HOLD)
    ) u_wheel_valve_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_dir(cmd_dir),
        .cmd_rate(cmd_rate), .meas_rate(meas_rate), .meas_press(meas_press),
        .press_min(press_min), .press_max(press_max), .eco_bypass(eco_bypass),
        .fault_clr(fault_clr), .flow_cmd(flow_cmd), .flow_dir(flow_dir),
        .bypass(bypass), .wheel_lost(wheel_lost)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick1();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic clr1();
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
    endtask

    task automatic recover();
        meas_press = 8'd100;
        meas_rate  = cmd_rate;
        clr1();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp;
        rst_n = 1'b0; tick = 1'b0; cmd_dir = 1'b0; cmd_rate = '0; meas_rate = '0;
        meas_press = 8'd100; press_min = PMIN; press_max = PMAX;
        eco_bypass = 1'b0; fault_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flow", flow_cmd, 0);
        chk("R1 dir", flow_dir, 0);
        chk("R1 bypass", bypass, 0);
        chk("R1 lost", wheel_lost, 0);

        // R2 R3: rising ramp with saturation, error inside tolerance
        cmd_rate = 8'd200; meas_rate = 8'd198; exp = 0;
        for (int k = 0; k < 70; k++) begin
            tick1();
            exp = (exp + STEP > 255) ? 255 : exp + STEP;
            chk("R2 R3 ramp up", flow_cmd, exp);
        end
        repeat (6) @(negedge clk);
        chk("R2 no tick hold", flow_cmd, 255);
        meas_rate = 8'd201;
        for (int k = 0; k < 70; k++) begin
            tick1();
            exp = (exp < STEP) ? 0 : exp - STEP;
            chk("R2 R3 ramp down", flow_cmd, exp);
        end
        meas_rate = 8'd198;
        repeat (3) tick1();
        meas_rate = cmd_rate;
        repeat (4) tick1();
        chk("R2 equal hold", flow_cmd, 12);
        chk("R5 tol ok", wheel_lost, 0);

        // R5: run lengths of over-tolerance error, both signs
        cmd_rate = 8'd100;
        for (int sgn = 0; sgn < 2; sgn++) begin
            for (int len = 1; len <= HOLD + 1; len++) begin
                meas_rate = (sgn == 0) ? 8'(100 + TOL + 1) : 8'(100 - TOL - 1);
                for (int k = 1; k <= len; k++) begin
                    tick1();
                    chk("R5 unsteady run", wheel_lost, (k > HOLD) ? 1 : 0);
                end
                if (len > HOLD) begin
                    chk("R6 fault bypass", bypass, 1);
                    chk("R6 fault flow", flow_cmd, 0);
                    recover();
                    chk("R7 clear", wheel_lost, 0);
                end else begin
                    meas_rate = cmd_rate;
                    tick1();
                end
            end
        end
        meas_rate = 8'(100 - TOL);
        repeat (HOLD + 6) tick1();
        chk("R5 error equal TOL", wheel_lost, 0);
        meas_rate = cmd_rate;

        // R4 R7: pressure sweep over every code
        for (int p = 0; p < 256; p++) begin
            meas_press = 8'(p);
            tick1();
            chk("R4 window", wheel_lost, (p < PMIN || p > PMAX) ? 1 : 0);
            if (p < PMIN || p > PMAX) begin
                clr1();
                chk("R7 clear while bad", wheel_lost, 1);
                recover();
                chk("R7 clear when good", wheel_lost, 0);
            end
        end

        // R7: clear refused while rate error large
        meas_press = 8'd10; tick1();
        meas_press = 8'd100; meas_rate = 8'd150;
        clr1();
        chk("R7 clear with speed error", wheel_lost, 1);
        recover();
        chk("R7 recovered", bypass, 0);

        // R8: energy-saving freewheel
        meas_rate = 8'd98;
        repeat (5) tick1();
        chk("R8 prep", flow_cmd, 20);
        eco_bypass = 1'b1;
        tick1();
        chk("R8 eco bypass", bypass, 1);
        chk("R8 eco flow", flow_cmd, 0);
        chk("R8 eco no lost", wheel_lost, 0);
        meas_press = 8'd10; meas_rate = 8'd250;
        repeat (HOLD + 3) tick1();
        chk("R8 unsupervised", wheel_lost, 0);
        meas_press = 8'd100; meas_rate = 8'd98; eco_bypass = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 exits only on tick", bypass, 1);
        tick1();
        chk("R8 exit", bypass, 0);
        chk("R8 exit flow", flow_cmd, 0);
        tick1();
        chk("R8 restart from zero", flow_cmd, STEP);

        // R9: reversal winds down first, error ignored while turning
        repeat (4) tick1();
        chk("R9 prep", flow_cmd, 20);
        cmd_dir = 1'b1; meas_rate = 8'd200;
        exp = 20;
        for (int k = 0; k < 5; k++) begin
            tick1();
            exp = exp - STEP;
            chk("R9 wind down", flow_cmd, exp);
            chk("R9 dir held", flow_dir, 0);
            chk("R9 no speed trip", wheel_lost, 0);
        end
        tick1();
        chk("R9 dir taken", flow_dir, 1);
        chk("R9 flow zero", flow_cmd, 0);
        meas_rate = 8'd98;
        repeat (2) tick1();
        cmd_dir = 1'b0; meas_rate = cmd_rate;
        tick1();
        chk("R9 turning", flow_cmd, 4);
        meas_press = 8'd250;
        tick1();
        chk("R4 trip while turning", wheel_lost, 1);
        recover();
        chk("R9 dir after clear", flow_dir, 0);

        // R10: fault and eco in the same tick
        meas_press = 8'd10; eco_bypass = 1'b1;
        tick1();
        chk("R10 pressure beats eco", wheel_lost, 1);
        meas_press = 8'd100;
        clr1();
        chk("R10 clear into eco lost", wheel_lost, 0);
        chk("R10 clear into eco bypass", bypass, 1);
        eco_bypass = 1'b0;
        tick1();
        chk("R10 eco left", bypass, 0);
        meas_rate = 8'(100 + TOL + 1);
        repeat (HOLD) tick1();
        eco_bypass = 1'b1;
        tick1();
        chk("R10 speed beats eco", wheel_lost, 1);
        eco_bypass = 1'b0;
        recover();
        chk("R10 final clear", wheel_lost, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule